// File: doc/BRIEF.md
# Shadow Return Address Stack

This block keeps an on-chip last-in-first-out copy of each function's return address and of the frame pointer the function saved, so that a corrupted stack frame is caught when the function exits. It follows a five-stage processor pipeline. Each cycle it takes an operation code from the decode stage that marks an instruction as a frame save, a frame restore or neither. The code moves with the instruction through two internal stage registers. When a save reaches the memory stage, the block copies the return address and frame pointer on the memory-stage inputs onto its internal stack. When a restore reaches the execute stage, the block pops the top entry and compares both halves with the values the program is about to use.

A mismatch in either half moves the judge state machine from `JDG_CLEAN` to `JDG_TRIPPED`. This raises a sticky alarm and records the expected and actual pair. The alarm stays set until the clear input is pulsed. The block does not wrap the stack. A restore with no entry sets an underflow flag, and a save with no free entry sets an overflow flag. Both flags are sticky. The stack occupancy is tracked by a second state machine with states `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. It moves to the state that matches the next count after every pop or push.

In the judge, `JDG_CLEAN` goes to `JDG_TRIPPED` on a mismatch. `JDG_TRIPPED` goes back to `JDG_CLEAN` on a clear pulse in a cycle with no new mismatch. Every other case holds the current state.

Top module: `shadow_ret_stack`

## Requirements
- R1: After reset, occupancy is 0, and alarm, bad_ra, bad_fp, underflow and overflow are all 0.
- R2: An id_op value of 2'b01 (save) pushes the pair on mem_ra/mem_fp. This happens at the second rising edge after the edge that sampled the op, so occupancy rises by one then. The values 2'b00 and 2'b11 are no-ops.
- R3: An id_op value of 2'b10 (restore) pops the top entry at the next rising edge and compares it with ex_ra/ex_fp, which are presented in the cycle after the op. If both halves match, no alarm is raised and occupancy falls by one.
- R4: If the return address half differs, alarm and bad_ra are set at the pop edge, and exp_ra/exp_fp and got_ra/got_fp hold the popped pair and the presented pair.
- R5: If only the frame pointer half differs, alarm and bad_fp are set and bad_ra stays 0.
- R6: Entries come back in reverse order of their pushes, under any interleaving of saves, restores and idle cycles.
- R7: The alarm is sticky. Later mismatches leave the recorded pair and the bad flags unchanged. A clear_flags pulse drops the alarm and the bad flags, unless a mismatch happens in the same cycle, in which case that mismatch is recorded.
- R8: A restore with an empty stack sets the sticky underflow flag, makes no comparison and leaves occupancy at 0.
- R9: A save with DEPTH entries held sets the sticky overflow flag and drops the pair. Occupancy stays DEPTH and the stored entries are unchanged.
- R10: When a save is in the memory stage and a restore is in the execute stage in the same cycle, the pop happens first and the push second. The compare uses the pre-push top. With a full stack the push succeeds. With an empty stack underflow is set and the push still lands.
- R11: clear_flags drops underflow and overflow unless a new event of that kind happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_op | input | 2 | Decode-stage class: 00 none, 01 save, 10 restore, 11 none |
| ex_ra | input | ADDR_W | Return address used by the restore now in execute |
| ex_fp | input | ADDR_W | Frame pointer used by the restore now in execute |
| mem_ra | input | ADDR_W | Return address written by the save now in memory stage |
| mem_fp | input | ADDR_W | Frame pointer written by the save now in memory stage |
| clear_flags | input | 1 | Clears alarm, bad, underflow and overflow flags |
| alarm | output | 1 | Sticky mismatch alarm |
| bad_ra | output | 1 | Recorded mismatch involved the return address |
| bad_fp | output | 1 | Recorded mismatch involved the frame pointer |
| exp_ra | output | ADDR_W | Recorded popped return address |
| exp_fp | output | ADDR_W | Recorded popped frame pointer |
| got_ra | output | ADDR_W | Recorded presented return address |
| got_fp | output | ADDR_W | Recorded presented frame pointer |
| underflow | output | 1 | Sticky restore-on-empty flag |
| overflow | output | 1 | Sticky save-on-full flag |
| occupancy | output | $clog2(DEPTH+1) | Entries held |

## Verification
A restore's result is due one rising edge after the edge that sampled its op. That result is the alarm, the bad flags, the recorded pair, underflow and the occupancy drop. A save's occupancy rise or overflow is due two edges after its op. The bench keeps three stage slots of its own and drives ex_* and mem_* from the slot that matches the pipeline position. It advances its reference model for exactly the operations that the next edge retires, and compares every output at the following falling edge. As a result, each result is checked in the cycle it first becomes due. Directed cases place a save and a restore so that they meet in the same edge, with the stack empty and with it full.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_RSVD    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_e;

    typedef enum logic {
        JDG_CLEAN,
        JDG_TRIPPED
    } jdg_state_e;

endpackage

// File: rtl/srs_stage_track.sv
module srs_stage_track
    import srs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] id_op,
    output logic       ex_restore,
    output logic       mem_save
);

    op_e ex_op;
    op_e mem_op;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_op  <= OP_NONE;
            mem_op <= OP_NONE;
        end else begin
            ex_op  <= op_e'(id_op);
            mem_op <= ex_op;
        end
    end

    always_comb begin
        ex_restore = 1'b0;
        mem_save   = 1'b0;
        unique case (ex_op)
            OP_RESTORE: ex_restore = 1'b1;
            OP_NONE, OP_SAVE, OP_RSVD: ex_restore = 1'b0;
        endcase
        unique case (mem_op)
            OP_SAVE: mem_save = 1'b1;
            OP_NONE, OP_RESTORE, OP_RSVD: mem_save = 1'b0;
        endcase
    end

endmodule

// File: rtl/srs_lifo.sv
module srs_lifo
    import srs_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic          push_req,
    input  logic [W-1:0]  push_ra,
    input  logic [W-1:0]  push_fp,
    output logic [W-1:0]  top_ra,
    output logic [W-1:0]  top_fp,
    output logic          pop_ok,
    output logic          pop_miss,
    output logic          push_miss,
    output logic [CW-1:0] count
);

    logic [W-1:0] ra_mem [DEPTH];
    logic [W-1:0] fp_mem [DEPTH];

    occ_state_e st, st_nx;
    logic [CW-1:0] cnt, cnt_nx, after_pop;
    logic          push_ok;
    logic [IW-1:0] wr_idx, rd_idx;

    // pop is resolved before push within one edge
    always_comb begin
        pop_ok    = 1'b0;
        pop_miss  = 1'b0;
        unique case (st)
            OCC_EMPTY: pop_miss = pop_req;
            OCC_PART, OCC_FULL: pop_ok = pop_req;
            default: pop_miss = pop_req;
        endcase
        after_pop = cnt - CW'(pop_ok);
        push_ok   = push_req && (after_pop != CW'(DEPTH));
        push_miss = push_req && !push_ok;
        cnt_nx    = after_pop + CW'(push_ok);
        if (cnt_nx == '0)
            st_nx = OCC_EMPTY;
        else if (cnt_nx == CW'(DEPTH))
            st_nx = OCC_FULL;
        else
            st_nx = OCC_PART;
        wr_idx = IW'(after_pop);
        rd_idx = (cnt == '0) ? '0 : IW'(cnt - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= OCC_EMPTY;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            ra_mem[wr_idx] <= push_ra;
            fp_mem[wr_idx] <= push_fp;
        end
    end

    always_comb begin
        top_ra = ra_mem[rd_idx];
        top_fp = fp_mem[rd_idx];
        count  = cnt;
    end

endmodule

// File: rtl/srs_judge.sv
module srs_judge
    import srs_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_valid,
    input  logic [W-1:0] want_ra,
    input  logic [W-1:0] want_fp,
    input  logic [W-1:0] seen_ra,
    input  logic [W-1:0] seen_fp,
    input  logic         clear,
    input  logic         uf_evt,
    input  logic         of_evt,
    output logic         alarm,
    output logic         bad_ra,
    output logic         bad_fp,
    output logic [W-1:0] rec_exp_ra,
    output logic [W-1:0] rec_exp_fp,
    output logic [W-1:0] rec_act_ra,
    output logic [W-1:0] rec_act_fp,
    output logic         uf_flag,
    output logic         of_flag
);

    jdg_state_e st, st_nx;
    logic ra_diff, fp_diff, mism, capture;

    always_comb begin
        ra_diff = cmp_valid && (want_ra != seen_ra);
        fp_diff = cmp_valid && (want_fp != seen_fp);
        mism    = ra_diff || fp_diff;
        st_nx   = st;
        capture = 1'b0;
        unique case (st)
            JDG_CLEAN: begin
                capture = mism;
                st_nx   = mism ? JDG_TRIPPED : JDG_CLEAN;
            end
            JDG_TRIPPED: begin
                capture = mism && clear;
                st_nx   = (clear && !mism) ? JDG_CLEAN : JDG_TRIPPED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= JDG_CLEAN;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_ra     <= 1'b0;
            bad_fp     <= 1'b0;
            rec_exp_ra <= '0;
            rec_exp_fp <= '0;
            rec_act_ra <= '0;
            rec_act_fp <= '0;
            uf_flag    <= 1'b0;
            of_flag    <= 1'b0;
        end else begin
            if (capture) begin
                bad_ra     <= ra_diff;
                bad_fp     <= fp_diff;
                rec_exp_ra <= want_ra;
                rec_exp_fp <= want_fp;
                rec_act_ra <= seen_ra;
                rec_act_fp <= seen_fp;
            end else if (clear) begin
                bad_ra <= 1'b0;
                bad_fp <= 1'b0;
            end
            uf_flag <= uf_evt || (uf_flag && !clear);
            of_flag <= of_evt || (of_flag && !clear);
        end
    end

    always_comb begin
        unique case (st)
            JDG_CLEAN:   alarm = 1'b0;
            JDG_TRIPPED: alarm = 1'b1;
        endcase
    end

endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
    import srs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        id_op,
    input  logic [ADDR_W-1:0] ex_ra,
    input  logic [ADDR_W-1:0] ex_fp,
    input  logic [ADDR_W-1:0] mem_ra,
    input  logic [ADDR_W-1:0] mem_fp,
    input  logic              clear_flags,
    output logic              alarm,
    output logic              bad_ra,
    output logic              bad_fp,
    output logic [ADDR_W-1:0] exp_ra,
    output logic [ADDR_W-1:0] exp_fp,
    output logic [ADDR_W-1:0] got_ra,
    output logic [ADDR_W-1:0] got_fp,
    output logic              underflow,
    output logic              overflow,
    output logic [CW-1:0]     occupancy
);

    logic ex_restore, mem_save;
    logic pop_ok, pop_miss, push_miss;
    logic [ADDR_W-1:0] top_ra, top_fp;

    srs_stage_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_op      (id_op),
        .ex_restore (ex_restore),
        .mem_save   (mem_save)
    );

    srs_lifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (ex_restore),
        .push_req  (mem_save),
        .push_ra   (mem_ra),
        .push_fp   (mem_fp),
        .top_ra    (top_ra),
        .top_fp    (top_fp),
        .pop_ok    (pop_ok),
        .pop_miss  (pop_miss),
        .push_miss (push_miss),
        .count     (occupancy)
    );

    srs_judge #(.W(ADDR_W)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (pop_ok),
        .want_ra    (top_ra),
        .want_fp    (top_fp),
        .seen_ra    (ex_ra),
        .seen_fp    (ex_fp),
        .clear      (clear_flags),
        .uf_evt     (pop_miss),
        .of_evt     (push_miss),
        .alarm      (alarm),
        .bad_ra     (bad_ra),
        .bad_fp     (bad_fp),
        .rec_exp_ra (exp_ra),
        .rec_exp_fp (exp_fp),
        .rec_act_ra (got_ra),
        .rec_act_fp (got_fp),
        .uf_flag    (underflow),
        .of_flag    (overflow)
    );

endmodule

// File: rtl/shadow_ret_stack_chk.sv
module shadow_ret_stack_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear_flags,
    input logic          alarm,
    input logic          bad_ra,
    input logic          bad_fp,
    input logic          underflow,
    input logic          overflow,
    input logic [CW-1:0] occupancy
);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CW'(DEPTH)); // R9

    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (occupancy == $past(occupancy)) ||
                 (occupancy == $past(occupancy) + CW'(1)) ||
                 (occupancy + CW'(1) == $past(occupancy))); // R10

    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clear_flags) |=> alarm); // R7

    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (bad_ra || bad_fp)); // R4

    AST_UF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> ($past(occupancy) == '0)); // R8

    AST_OF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(occupancy) == CW'(DEPTH))); // R9

endmodule

bind shadow_ret_stack shadow_ret_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_flags (clear_flags),
    .alarm       (alarm),
    .bad_ra      (bad_ra),
    .bad_fp      (bad_fp),
    .underflow   (underflow),
    .overflow    (overflow),
    .occupancy   (occupancy)
);

// File: tb/shadow_ret_stack_bench.sv
`timescale 1ns/1ps
module shadow_ret_stack_bench;

    localparam int W     = 32;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [1:0] K_NONE = 2'b00, K_SAVE = 2'b01, K_REST = 2'b10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, clear_flags;
    logic [1:0] id_op;
    logic [W-1:0] ex_ra, ex_fp, mem_ra, mem_fp;
    logic alarm, bad_ra, bad_fp, underflow, overflow;
    logic [W-1:0] exp_ra, exp_fp, got_ra, got_fp;
    logic [CW-1:0] occupancy;

    shadow_ret_stack #(.ADDR_W(W), .DEPTH(DEPTH)) u_shadow_ret_stack (
        .clk(clk), .rst_n(rst_n), .id_op(id_op),
        .ex_ra(ex_ra), .ex_fp(ex_fp), .mem_ra(mem_ra), .mem_fp(mem_fp),
        .clear_flags(clear_flags), .alarm(alarm), .bad_ra(bad_ra), .bad_fp(bad_fp),
        .exp_ra(exp_ra), .exp_fp(exp_fp), .got_ra(got_ra), .got_fp(got_fp),
        .underflow(underflow), .overflow(overflow), .occupancy(occupancy)
    );

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference model
    logic [W-1:0] m_ra [DEPTH];
    logic [W-1:0] m_fp [DEPTH];
    int m_cnt = 0;
    logic m_alarm = 0, m_bra = 0, m_bfp = 0, m_uf = 0, m_of = 0;
    logic [W-1:0] m_era = '0, m_efp = '0, m_gra = '0, m_gfp = '0;

    // bench stage slots
    logic [1:0] q_id_k = K_NONE, q_ex_k = K_NONE, q_mem_k = K_NONE;
    logic [W-1:0] q_id_ra = '0, q_id_fp = '0, q_ex_ra = '0, q_ex_fp = '0;
    logic [W-1:0] q_mem_ra = '0, q_mem_fp = '0;
    int q_id_md = 0, q_ex_md = 0;

    task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic observe();
        check(tag, "occupancy", 64'(occupancy), 64'(m_cnt));
        check(tag, "alarm", 64'(alarm), 64'(m_alarm));
        check(tag, "bad_ra", 64'(bad_ra), 64'(m_bra));
        check(tag, "bad_fp", 64'(bad_fp), 64'(m_bfp));
        check(tag, "underflow", 64'(underflow), 64'(m_uf));
        check(tag, "overflow", 64'(overflow), 64'(m_of));
        if (m_alarm) begin
            check(tag, "exp pair", {exp_ra, exp_fp}, {m_era, m_efp});
            check(tag, "got pair", {got_ra, got_fp}, {m_gra, m_gfp});
        end
    endtask

    task automatic step(logic [1:0] op, logic [W-1:0] ra, logic [W-1:0] fp, int md, logic clr);
        logic pop_ok, mism, rd, fd, uf_e, of_e;
        logic [W-1:0] tra, tfp;
        @(negedge clk);
        observe();
        q_mem_k = q_ex_k; q_mem_ra = q_ex_ra; q_mem_fp = q_ex_fp;
        q_ex_k = q_id_k; q_ex_ra = q_id_ra; q_ex_fp = q_id_fp; q_ex_md = q_id_md;
        q_id_k = op; q_id_ra = ra; q_id_fp = fp; q_id_md = md;
        if (q_ex_k == K_REST) begin
            if (m_cnt > 0) begin
                q_ex_ra = m_ra[m_cnt-1];
                q_ex_fp = m_fp[m_cnt-1];
            end
            if (q_ex_md == 1) q_ex_ra = q_ex_ra ^ 32'h0000_0004;
            if (q_ex_md == 2) q_ex_fp = q_ex_fp ^ 32'h0000_0010;
        end
        id_op = op; ex_ra = q_ex_ra; ex_fp = q_ex_fp;
        mem_ra = q_mem_ra; mem_fp = q_mem_fp; clear_flags = clr;
        // model the coming edge: pop first, then push
        pop_ok = (q_ex_k == K_REST) && (m_cnt > 0);
        uf_e   = (q_ex_k == K_REST) && (m_cnt == 0);
        tra = '0; tfp = '0; rd = 0; fd = 0;
        if (pop_ok) begin
            tra = m_ra[m_cnt-1]; tfp = m_fp[m_cnt-1];
            rd = (tra != q_ex_ra); fd = (tfp != q_ex_fp);
            m_cnt--;
        end
        mism = rd || fd;
        of_e = 0;
        if (q_mem_k == K_SAVE) begin
            if (m_cnt == DEPTH) of_e = 1;
            else begin
                m_ra[m_cnt] = q_mem_ra; m_fp[m_cnt] = q_mem_fp; m_cnt++;
            end
        end
        if (mism && (!m_alarm || clr)) begin
            m_alarm = 1; m_bra = rd; m_bfp = fd;
            m_era = tra; m_efp = tfp; m_gra = q_ex_ra; m_gfp = q_ex_fp;
        end else if (clr) begin
            m_alarm = 0; m_bra = 0; m_bfp = 0;
        end
        m_uf = uf_e || (m_uf && !clr);
        m_of = of_e || (m_of && !clr);
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) step(K_NONE, '0, '0, 0, 1'b0);
    endtask

    task automatic save_rand();
        step(K_SAVE, $urandom, $urandom, 0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; id_op = K_NONE; clear_flags = 0;
        ex_ra = '0; ex_fp = '0; mem_ra = '0; mem_fp = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1"; settle(2);
        // R2 saves land two edges after decode; 2'b11 is a no-op
        tag = "R2";
        step(K_SAVE, 32'h1000_0100, 32'h7fff_0f00, 0, 0);
        step(K_SAVE, 32'h1000_0200, 32'h7fff_0e00, 0, 0);
        step(2'b11, 32'hdead_beef, 32'hdead_beef, 0, 0);
        step(K_SAVE, 32'h1000_0300, 32'h7fff_0d00, 0, 0);
        settle(3);
        // R3 matching restore
        tag = "R3"; step(K_REST, '0, '0, 0, 0); settle(2);
        // R6 reverse order
        tag = "R6"; step(K_REST, '0, '0, 0, 0); step(K_REST, '0, '0, 0, 0); settle(2);
        // R4 return address mismatch
        tag = "R4"; save_rand(); settle(2); step(K_REST, '0, '0, 1, 0); settle(2);
        // R7 sticky, first record kept, then cleared
        tag = "R7"; save_rand(); settle(2); step(K_REST, '0, '0, 2, 0); settle(2);
        step(K_NONE, '0, '0, 0, 1); settle(2);
        // R5 frame pointer only
        tag = "R5"; save_rand(); settle(2); step(K_REST, '0, '0, 2, 0); settle(2);
        step(K_NONE, '0, '0, 0, 1); settle(2);
        // R8 restore on empty
        tag = "R8"; step(K_REST, 32'h1, 32'h2, 0, 0); settle(3);
        // R11 clear drops underflow
        tag = "R11"; step(K_NONE, '0, '0, 0, 1); settle(2);
        // R9 overflow drops the pair, contents survive
        tag = "R9";
        for (int i = 0; i < DEPTH + 1; i++) save_rand();
        settle(3);
        for (int i = 0; i < DEPTH; i++) step(K_REST, '0, '0, 0, 0);
        settle(3);
        step(K_NONE, '0, '0, 0, 1); settle(2);
        // R10 pop-then-push in one edge, empty and full
        tag = "R10";
        step(K_SAVE, 32'h2000_0000, 32'h7000_0000, 0, 0);
        step(K_REST, '0, '0, 0, 0);
        settle(3);
        step(K_NONE, '0, '0, 0, 1);
        for (int i = 0; i < DEPTH - 1; i++) save_rand();
        settle(3);
        step(K_SAVE, 32'h2000_1111, 32'h7000_1111, 0, 0);
        step(K_REST, '0, '0, 0, 0);
        settle(3);
        for (int i = 0; i < DEPTH; i++) step(K_REST, '0, '0, 0, 0);
        settle(3);
        step(K_NONE, '0, '0, 0, 1); settle(2);
        // random mix, R6 ordering under interleaving
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            int r, md;
            logic [1:0] op;
            r  = int'($urandom % 10);
            op = (r < 4) ? K_SAVE : (r < 8) ? K_REST : (r == 8) ? 2'b11 : K_NONE;
            md = ($urandom % 8 == 0) ? int'(1 + $urandom % 2) : 0;
            step(op, $urandom, $urandom, md, ($urandom % 40) == 0);
        end
        settle(4);
        finish_run();
    end

endmodule